// File: doc/BRIEF.md
# Core special register access unit

This unit gives a processor core its move-from and move-to path into a small bank of core special registers. Each request carries a 16-bit register offset taken from an instruction immediate, a 32-bit write value, a direction bit and the current privilege state of the core. Reads return the selected register one cycle later. Writes commit at the clock edge that samples the request, subject to the register's access class, its minimum ISA version and the privilege of the core.

Every register in the bank has a fixed offset, one of three access classes (read-only, all-access, init-protected) and the lowest ISA version that provides it. No init-lock source is connected, so init-protected registers behave exactly like all-access ones. The processor status word sits apart from the bank on a dedicated path with its own write mask. A move-to issued outside supervisor mode changes nothing and raises a one-cycle privilege-trap pulse. A move-to aimed at a read-only register is dropped silently.

Top module: `core_sreg_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rd_valid` and `priv_trap` are 0. Bank registers start at their reset values: 0xFE00=0, 0xFE08=0, 0xFE10=0x00000100, 0xFE14=0, 0xFE18=0x0000C0DE. The status word at 0xFE04 starts at 0x00000B80.
- R2: A read request (`req_valid`=1, `req_write`=0) in cycle N gives `rd_valid`=1 in cycle N+1, with `rd_data` equal to the selected register. Reads are allowed in both privilege modes.
- R3: A read of an offset that maps to no register returns 0. A read of a register whose minimum ISA version is above `ISA_VER` also returns 0. With the default `ISA_VER`=1, offset 0xFE1C (minimum version 2) is gated off, and writes to it have no effect.
- R4: A supervisor write (`sup_mode`=1) to an all-access register (0xFE00, 0xFE08) commits at the edge that samples it. A read issued in the very next cycle returns the new value.
- R5: Init-protected registers (0xFE10, and 0xFE14 with minimum version 1) accept supervisor writes exactly like all-access registers.
- R6: A write to the read-only register 0xFE18 leaves it unchanged and raises no trap.
- R7: A write request with `sup_mode`=0 gives `priv_trap`=1 for exactly the next cycle and changes no register, including the status word.
- R8: The status word at 0xFE04 is read and written through its own path. A supervisor write updates only the bits set in `STATUS_WMASK` (default 0xFF000F7F), and all other bits keep their old value.
- R9: A write request never produces `rd_valid`. `priv_trap` is never raised after a read request or after a supervisor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe, one request per cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_offset | input | 16 | Register offset from the instruction immediate |
| req_wdata | input | 32 | Write value |
| sup_mode | input | 1 | Core is in supervisor mode |
| rd_data | output | 32 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result present this cycle |
| priv_trap | output | 1 | One-cycle pulse for a write outside supervisor mode |

## Verification
Two functions meet when a write commit and a read of the same register fall on neighbouring edges. The write lands at one edge, and the read sampled at the next edge must already return the new value. The bench provokes this by issuing a write and then a read of the same offset back to back, on plain, init-protected and status registers. A scoreboard judges each cycle against a bench-side register model. The same back-to-back pattern also pairs a trapped user write with an immediate read, to show that the trap pulse and an unchanged value appear together.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int SREG_DW     = 32;
    localparam int SREG_AW     = 16;
    localparam int NUM_SREG    = 6;
    localparam logic [SREG_AW-1:0] STATUS_ADDR = 16'hFE04;

    typedef enum logic [1:0] {
        ACC_RO    = 2'd0,
        ACC_ALL   = 2'd1,
        ACC_EINIT = 2'd2
    } acc_class_e;

    typedef struct packed {
        logic [SREG_AW-1:0] addr;
        acc_class_e         cls;
        logic [3:0]         min_ver;
        logic [SREG_DW-1:0] rst_val;
    } sreg_desc_t;

    typedef struct packed {
        logic [NUM_SREG-1:0] hit;
        logic [NUM_SREG-1:0] wr_perm;
        logic                status_hit;
    } sreg_sel_t;

    // Descriptor of each bank entry: offset, class, lowest ISA version, reset value.
    function automatic sreg_desc_t sreg_desc(input int idx);
        sreg_desc_t d;
        case (idx)
            0:       d = '{addr: 16'hFE00, cls: ACC_ALL,   min_ver: 4'd0, rst_val: 32'h0000_0000};
            1:       d = '{addr: 16'hFE08, cls: ACC_ALL,   min_ver: 4'd0, rst_val: 32'h0000_0000};
            2:       d = '{addr: 16'hFE10, cls: ACC_EINIT, min_ver: 4'd0, rst_val: 32'h0000_0100};
            3:       d = '{addr: 16'hFE14, cls: ACC_EINIT, min_ver: 4'd1, rst_val: 32'h0000_0000};
            4:       d = '{addr: 16'hFE18, cls: ACC_RO,    min_ver: 4'd0, rst_val: 32'h0000_C0DE};
            default: d = '{addr: 16'hFE1C, cls: ACC_ALL,   min_ver: 4'd2, rst_val: 32'h0000_0000};
        endcase
        return d;
    endfunction

    // No init-lock source exists: the protected class writes like all-access.
    function automatic logic class_writable(input acc_class_e c);
        return (c == ACC_ALL) || (c == ACC_EINIT);
    endfunction

    function automatic logic ver_enabled(input int unsigned isa_ver, input sreg_desc_t d);
        return isa_ver >= int'(unsigned'(d.min_ver));
    endfunction

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
    import sreg_pkg::*;
#(
    parameter int unsigned ISA_VER = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SREG_AW-1:0] offset,
    output sreg_sel_t          sel
);

    logic [NUM_SREG-1:0] hit_vec;
    logic [NUM_SREG-1:0] perm_vec;
    logic                status_hit;

    for (genvar i = 0; i < NUM_SREG; i++) begin : g_entry
        localparam sreg_desc_t D  = sreg_desc(i);
        localparam logic       EN = ver_enabled(ISA_VER, D);
        assign hit_vec[i]  = EN && (offset == D.addr);
        assign perm_vec[i] = EN && (offset == D.addr) && class_writable(D.cls);
    end

    assign status_hit = (offset == STATUS_ADDR);
    assign sel = '{hit: hit_vec, wr_perm: perm_vec, status_hit: status_hit};

    // R3: offsets are distinct, so at most one path is selected
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_vec, status_hit}));

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int unsigned ISA_VER = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SREG-1:0] we,
    input  logic [SREG_DW-1:0] wdata,
    output logic [SREG_DW-1:0] q [NUM_SREG]
);

    for (genvar i = 0; i < NUM_SREG; i++) begin : g_reg
        localparam sreg_desc_t D  = sreg_desc(i);
        localparam logic       EN = ver_enabled(ISA_VER, D);
        if (!EN) begin : g_absent
            assign q[i] = '0;
        end else if (!class_writable(D.cls)) begin : g_const
            assign q[i] = D.rst_val;
        end else begin : g_flop
            logic [SREG_DW-1:0] val;
            always_ff @(posedge clk) begin
                if (rst)        val <= D.rst_val;
                else if (we[i]) val <= wdata;
            end
            assign q[i] = val;
        end
    end

endmodule

// File: rtl/sreg_status.sv
module sreg_status
    import sreg_pkg::*;
#(
    parameter logic [SREG_DW-1:0] RST_VAL = 32'h0000_0B80,
    parameter logic [SREG_DW-1:0] WMASK   = 32'hFF00_0F7F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SREG_DW-1:0] wdata,
    output logic [SREG_DW-1:0] q
);

    localparam logic [SREG_DW-1:0] KEEP = ~WMASK;

    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= (q & KEEP) | (wdata & WMASK);
    end

    // R8: bits outside the write mask survive every write
    p_status_mask_r8: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & KEEP) == $past(q & KEEP)));

endmodule

// File: rtl/core_sreg_unit.sv
module core_sreg_unit
    import sreg_pkg::*;
#(
    parameter int unsigned        ISA_VER      = 1,
    parameter logic [SREG_DW-1:0] STATUS_RST   = 32'h0000_0B80,
    parameter logic [SREG_DW-1:0] STATUS_WMASK = 32'hFF00_0F7F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [SREG_AW-1:0] req_offset,
    input  logic [SREG_DW-1:0] req_wdata,
    input  logic               sup_mode,
    output logic [SREG_DW-1:0] rd_data,
    output logic               rd_valid,
    output logic               priv_trap
);

    sreg_sel_t          sel;
    logic [SREG_DW-1:0] bank_q [NUM_SREG];
    logic [SREG_DW-1:0] status_q;
    logic [NUM_SREG-1:0] bank_we;
    logic               status_we;
    logic               wr_ok;
    logic               wr_denied;
    logic               rd_req;
    logic [SREG_DW-1:0] rd_mux;

    assign rd_req    = req_valid && !req_write;
    assign wr_ok     = req_valid &&  req_write &&  sup_mode;
    assign wr_denied = req_valid &&  req_write && !sup_mode;
    assign bank_we   = {NUM_SREG{wr_ok}} & sel.wr_perm;
    assign status_we = wr_ok && sel.status_hit;

    sreg_decode #(.ISA_VER(ISA_VER)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .offset (req_offset),
        .sel    (sel)
    );

    sreg_bank #(.ISA_VER(ISA_VER)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (bank_we),
        .wdata (req_wdata),
        .q     (bank_q)
    );

    sreg_status #(.RST_VAL(STATUS_RST), .WMASK(STATUS_WMASK)) u_status (
        .clk   (clk),
        .rst   (rst),
        .we    (status_we),
        .wdata (req_wdata),
        .q     (status_q)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_SREG; i++) begin
            if (sel.hit[i]) rd_mux = rd_mux | bank_q[i];
        end
        if (sel.status_hit) rd_mux = status_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            priv_trap <= 1'b0;
        end else begin
            rd_valid  <= rd_req;
            rd_data   <= rd_req ? rd_mux : '0;
            priv_trap <= wr_denied;
        end
    end

    // R2: every read request is answered in the next cycle
    p_read_valid_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    // R9: a write never yields read data
    p_write_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rd_valid);

    // R7: a user-mode write traps in the next cycle
    p_user_trap_r7: assert property (@(posedge clk) disable iff (rst)
        wr_denied |=> priv_trap);

    // R9: reads and supervisor writes never trap
    p_no_trap_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!req_write || sup_mode)) |=> !priv_trap);

    // R7: a trapped write leaves the status word untouched
    p_user_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
        wr_denied |=> $stable(status_q));

endmodule

// File: tb/core_sreg_unit_test.sv
module core_sreg_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SW_RST  = 32'h0000_0B80;
    localparam logic [31:0] SW_MASK = 32'hFF00_0F7F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        sup_mode = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        priv_trap;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          exp_rv;
        bit          exp_trap;
        logic [31:0] exp_data;
        string       tag;
    } sb_item_t;

    sb_item_t sb [$];

    // bench model slots: 0 FE00, 1 FE08, 2 FE10, 3 FE14, 4 FE18 (read-only), 5 status FE04
    logic [31:0] mdl [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    core_sreg_unit uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .sup_mode   (sup_mode),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .priv_trap  (priv_trap)
    );

    function automatic int slot_of(input logic [15:0] off);
        case (off)
            16'hFE00: return 0;
            16'hFE08: return 1;
            16'hFE10: return 2;
            16'hFE14: return 3;
            16'hFE18: return 4;
            16'hFE04: return 5;
            default:  return -1;   // unmapped, or gated off as 0xFE1C is
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // driver: one request per call, expected result pushed to the scoreboard
    task automatic op(input bit wr, input bit sup, input logic [15:0] off,
                      input logic [31:0] wd, input string tag);
        sb_item_t it;
        int s;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        sup_mode   = sup;
        req_offset = off;
        req_wdata  = wd;
        s = slot_of(off);
        it.tag      = tag;
        it.exp_rv   = !wr;
        it.exp_trap = wr && !sup;
        it.exp_data = (!wr && s >= 0) ? mdl[s] : 32'h0;
        sb.push_back(it);
        if (wr && sup && s >= 0) begin
            if (s == 5)      mdl[5] = (mdl[5] & ~SW_MASK) | (wd & SW_MASK);
            else if (s != 4) mdl[s] = wd;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            sb_item_t it;
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
            it.tag = "idle";
            it.exp_rv = 1'b0;
            it.exp_trap = 1'b0;
            it.exp_data = '0;
            sb.push_back(it);
        end
    endtask

    // monitor: sample a quarter period after the edge that registered the request
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            check(it.tag, "rd_valid", {31'b0, rd_valid}, {31'b0, it.exp_rv});
            check(it.tag, "priv_trap", {31'b0, priv_trap}, {31'b0, it.exp_trap});
            if (it.exp_rv) check(it.tag, "rd_data", rd_data, it.exp_data);
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mdl[0] = 32'h0;
        mdl[1] = 32'h0;
        mdl[2] = 32'h0000_0100;
        mdl[3] = 32'h0;
        mdl[4] = 32'h0000_C0DE;
        mdl[5] = SW_RST;

        repeat (3) @(negedge clk);
        check("R1", "rd_valid in reset", {31'b0, rd_valid}, 32'h0);
        check("R1", "priv_trap in reset", {31'b0, priv_trap}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "rd_valid after reset", {31'b0, rd_valid}, 32'h0);
        check("R1", "priv_trap after reset", {31'b0, priv_trap}, 32'h0);

        // R1/R2: reset values, read in both privilege modes
        op(0, 1, 16'hFE00, 0, "R1 fe00");
        op(0, 0, 16'hFE08, 0, "R1 fe08");
        op(0, 1, 16'hFE10, 0, "R1 fe10");
        op(0, 0, 16'hFE14, 0, "R2 fe14 user read");
        op(0, 1, 16'hFE18, 0, "R1 fe18");
        op(0, 0, 16'hFE04, 0, "R1 status");

        // R3: unmapped and gated offsets read zero; gated write has no effect
        op(0, 1, 16'h1234, 0, "R3 unmapped");
        op(0, 1, 16'hFE1C, 0, "R3 gated");
        op(1, 1, 16'hFE1C, 32'hDEAD_BEEF, "R3 gated write");
        op(0, 1, 16'hFE1C, 0, "R3 gated after write");
        op(0, 1, 16'hFE02, 0, "R3 odd offset");

        // R4: write then immediate read of the same register
        op(1, 1, 16'hFE00, 32'hA5A5_1234, "R4 write fe00");
        op(0, 1, 16'hFE00, 0, "R4 readback fe00");
        op(1, 1, 16'hFE08, 32'h0F0F_F0F0, "R4 write fe08");
        op(0, 0, 16'hFE08, 0, "R4 readback fe08");
        op(0, 1, 16'hFE00, 0, "R4 fe00 kept");

        // R5: init-protected registers act as all-access
        op(1, 1, 16'hFE10, 32'h1357_9BDF, "R5 write fe10");
        op(0, 1, 16'hFE10, 0, "R5 readback fe10");
        op(1, 1, 16'hFE14, 32'hFFFF_FFFF, "R5 write fe14");
        op(0, 1, 16'hFE14, 0, "R5 readback fe14");

        // R6: read-only write is dropped without a trap
        op(1, 1, 16'hFE18, 32'h1111_2222, "R6 write ro");
        op(0, 1, 16'hFE18, 0, "R6 ro unchanged");

        // R7: user-mode writes trap and change nothing
        op(1, 0, 16'hFE08, 32'h7777_7777, "R7 user write fe08");
        op(0, 1, 16'hFE08, 0, "R7 fe08 unchanged");
        op(1, 0, 16'hFE04, 32'hFFFF_FFFF, "R7 user write status");
        op(0, 1, 16'hFE04, 0, "R7 status unchanged");
        op(1, 0, 16'hFE18, 32'h0, "R7 user write ro");
        op(1, 0, 16'hFE10, 32'h0, "R7 back-to-back trap");
        op(0, 0, 16'hFE10, 0, "R7 fe10 unchanged");

        // R8: status word masked writes
        op(1, 1, 16'hFE04, 32'hFFFF_FFFF, "R8 status all ones");
        op(0, 1, 16'hFE04, 0, "R8 status readback ones");
        op(1, 1, 16'hFE04, 32'h0000_0000, "R8 status all zeros");
        op(0, 1, 16'hFE04, 0, "R8 status readback zeros");
        op(1, 1, 16'hFE04, 32'h5A5A_A5A5, "R8 status pattern");
        op(0, 0, 16'hFE04, 0, "R8 status readback pattern");

        // R9: writes never give read data; idle cycles are quiet
        op(1, 1, 16'hFE00, 32'h0, "R9 write no valid");
        op(1, 1, 16'h0000, 32'h0, "R9 unmapped write");
        idle(3);
        op(0, 1, 16'hFE00, 0, "R9 fe00 final");
        idle(4);

        wait (sb.size() == 0);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule